// File: doc/BRIEF.md
# Frame-Synchronous DAC Channel Stager

This block keeps the output codes for a bank of 32 digital-to-analog converter channels, each a 16-bit unsigned code with 0x8000 as the zero-volt midpoint. Software-style writes reach it as an address plus a wide data word. An address below the channel count stages new codes. When the group size is one, a write carries a single channel. Otherwise it carries an aligned group of 2^k channels packed two per 32-bit word. Higher addresses load the per-channel control masks and a small configuration register.

A free-running frame timer marks a boundary every 98 clocks. At each boundary the block decides, for every channel at once, whether the staged code is sent. A channel is sent when it has fresh data and is not held. A held channel is sent only when a one-shot release mask names it. A channel in the continuous mask is sent every frame. The chosen codes and a per-channel strobe change together on the frame boundary, so every update is atomic across channels. A clear bit in the configuration forces every output to mid-scale.

Top module: `dac_frame_stager`

## Requirements
- R1: After reset every channel output is 0x8000, all strobes, configuration bits, LED bits and the alignment error are 0, and the hold, release and continuous masks are empty.
- R2: `frame_start` is a one-cycle pulse that repeats every 98 clocks.
- R3: Channel outputs and strobes change only in the cycle in which `frame_start` is high. An unheld channel written since the previous frame shows its new code, with its strobe bit set, in the next `frame_start` cycle. Channels that are not sent keep their code and show a clear strobe bit.
- R4: Address 0x21 loads the hold mask from data bits [31:0], where bit n means channel n. A held channel with fresh data is not sent at the frame.
- R5: Address 0x20 loads a release mask from bits [31:0]. The named channels send their staged code at the next frame, and then the mask clears itself, so the frame after that carries no strobe for them.
- R6: Address 0x25 loads a continuous mask from bits [31:0]. The named channels are sent, with their strobe set, in every frame, even with no new data.
- R7: With `grp_log2` = k, a write to channel address a covers channels a to a+2^k-1. The code for channel a+i is taken from data bits [16i+15:16i], so even channels use the low half of each 32-bit word and odd channels use the high half.
- R8: In a group write only the first 2*`wr_nwords` channels take data. The remaining channels of the group are staged as 0x0000.
- R9: A channel write is ignored, and the sticky `align_err` is set, when the low k bits of the address are not zero or when k exceeds 5.
- R10: Address 0x22 loads the 4-bit configuration from data bits [3:0]: bit 0 is reset request, bit 1 is front-end power-down, bit 2 is DAC clear and bit 3 is error clear. While bit 3 is set, `align_err` reads 0 in the following cycle. Address 0x23 loads the 8-bit LED field from bits [7:0].
- R11: While the DAC clear bit is set, each frame drives every output to 0x8000 and sets all 32 strobes.
- R12: A channel write presented in the same cycle that `frame_start` is high is not part of that frame. It appears at the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Channel or register address |
| wr_data | input | 512 | Write data, packed 16-bit codes or 32-bit mask |
| wr_nwords | input | 5 | Number of valid 32-bit words in a group write |
| grp_log2 | input | 3 | Log2 of the channel group size |
| frame_start | output | 1 | Frame boundary pulse |
| dac_word | output | 512 | 32 channel codes, channel n at bits [16n+15:16n] |
| dac_strobe | output | 32 | Per-channel sent-this-frame flag |
| cfg_bits | output | 4 | Configuration register |
| led_bits | output | 8 | LED field |
| align_err | output | 1 | Sticky misaligned-write flag |

## Verification
A channel write and the frame commit can meet in a single cycle. So can a release-mask write and the automatic clearing of that mask. The bench syncs to a frame, then issues a write while `frame_start` is high. It checks that the output is unchanged during that frame and changes only at the next boundary. Assertions check that the release mask empties after any frame that did not reload it, and that outputs hold steady away from the commit edge.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
    localparam int NCH       = 32;
    localparam int CH_W      = 16;
    localparam int FRAME_LEN = 98;
    localparam logic [15:0] MID_CODE = 16'h8000;

    typedef struct packed {
        logic err_clr;   // bit 3
        logic dac_clr;   // bit 2
        logic fe_pd;     // bit 1
        logic rst_req;   // bit 0
    } cfg_t;

    typedef enum logic [7:0] {
        A_REL  = 8'h20,
        A_HOLD = 8'h21,
        A_CFG  = 8'h22,
        A_LED  = 8'h23,
        A_CONT = 8'h25
    } reg_addr_e;

    function automatic logic grp_bad(input int addr, input int lg, input int lg_max);
        if (lg > lg_max) return 1'b1;
        return (addr & ((1 << lg) - 1)) != 0;
    endfunction
endpackage

// File: rtl/dac_frame_timer.sv
module dac_frame_timer #(
    parameter int FRAME_LEN = 98
) (
    input  logic clk,
    input  logic rst,
    output logic fire,
    output logic frame_start
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cnt;

    assign fire = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            frame_start <= 1'b0;
        end else begin
            cnt         <= fire ? '0 : cnt + 1'b1;
            frame_start <= fire;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R2
endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs
    import dac_stage_pkg::*;
#(
    parameter int NCH  = 32,
    parameter int CH_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [NCH*CH_W-1:0] wr_data,
    input  logic [4:0]          wr_nwords,
    input  logic [2:0]          grp_log2,
    output logic [NCH*CH_W-1:0] stg_flat,
    output logic [NCH-1:0]      send,
    output cfg_t                cfg,
    output logic [7:0]          leds,
    output logic                err
);
    localparam int LOG2_MAX = $clog2(NCH);

    logic [NCH-1:0] hold, cont, rel, dirty;
    logic           in_range, misalign, grp_ok;
    int             a_i, g_w;

    always_comb begin
        a_i      = int'(wr_addr);
        g_w      = 1 << int'(grp_log2);
        in_range = wr_en && (a_i < NCH);
        misalign = in_range && grp_bad(a_i, int'(grp_log2), LOG2_MAX);
        grp_ok   = in_range && !misalign;
        send     = cont | rel | (dirty & ~hold);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        int          idx;
        logic        hit;
        logic [CH_W-1:0] val;
        always_comb begin
            idx = c - a_i;
            hit = grp_ok && (idx >= 0) && (idx < g_w);
            if (!hit) idx = 0;
            val = (idx < 2 * int'(wr_nwords)) ? wr_data[idx*CH_W +: CH_W] : '0;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_flat[c*CH_W +: CH_W] <= CH_W'(MID_CODE);
                dirty[c]                 <= 1'b0;
            end else if (hit) begin
                stg_flat[c*CH_W +: CH_W] <= val;
                dirty[c]                 <= 1'b1;
            end else if (fire && send[c]) begin
                dirty[c]                 <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            cont <= '0;
            rel  <= '0;
            cfg  <= '0;
            leds <= '0;
            err  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_HOLD) hold <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == A_CONT) cont <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == A_CFG)  cfg  <= cfg_t'(wr_data[3:0]);
            if (wr_en && wr_addr == A_LED)  leds <= wr_data[7:0];
            if (wr_en && wr_addr == A_REL)  rel  <= wr_data[NCH-1:0];
            else if (fire)                  rel  <= '0;
            if (cfg.err_clr)                err  <= 1'b0;
            else if (misalign)              err  <= 1'b1;
        end
    end

    AST_REL_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (fire && !(wr_en && wr_addr == A_REL)) |=> (rel == '0)); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        cfg.err_clr |=> !err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (misalign && !cfg.err_clr) |=> err); // R9
endmodule

// File: rtl/dac_commit.sv
module dac_commit
    import dac_stage_pkg::*;
#(
    parameter int NCH  = 32,
    parameter int CH_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                dac_clr,
    input  logic [NCH-1:0]      send,
    input  logic [NCH*CH_W-1:0] stg_flat,
    output logic [NCH*CH_W-1:0] dac_word,
    output logic [NCH-1:0]      dac_strobe
);
    for (genvar c = 0; c < NCH; c++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                dac_word[c*CH_W +: CH_W] <= CH_W'(MID_CODE);
                dac_strobe[c]            <= 1'b0;
            end else if (fire) begin
                if (dac_clr) begin
                    dac_word[c*CH_W +: CH_W] <= CH_W'(MID_CODE);
                    dac_strobe[c]            <= 1'b1;
                end else begin
                    if (send[c]) dac_word[c*CH_W +: CH_W] <= stg_flat[c*CH_W +: CH_W];
                    dac_strobe[c] <= send[c];
                end
            end else begin
                dac_strobe[c] <= 1'b0;
            end
        end
    end

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(dac_word)); // R3
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        (fire && dac_clr) |=> (&dac_strobe)); // R11
endmodule

// File: rtl/dac_frame_stager.sv
module dac_frame_stager
    import dac_stage_pkg::*;
#(
    parameter int NCH       = dac_stage_pkg::NCH,
    parameter int CH_W      = dac_stage_pkg::CH_W,
    parameter int FRAME_LEN = dac_stage_pkg::FRAME_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [NCH*CH_W-1:0] wr_data,
    input  logic [4:0]          wr_nwords,
    input  logic [2:0]          grp_log2,
    output logic                frame_start,
    output logic [NCH*CH_W-1:0] dac_word,
    output logic [NCH-1:0]      dac_strobe,
    output logic [3:0]          cfg_bits,
    output logic [7:0]          led_bits,
    output logic                align_err
);
    logic                fire;
    logic [NCH-1:0]      send;
    logic [NCH*CH_W-1:0] stg_flat;
    cfg_t                cfg;

    dac_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk(clk), .rst(rst), .fire(fire), .frame_start(frame_start)
    );

    dac_stage_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .fire(fire), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_nwords(wr_nwords), .grp_log2(grp_log2),
        .stg_flat(stg_flat), .send(send), .cfg(cfg), .leds(led_bits),
        .err(align_err)
    );

    dac_commit #(.NCH(NCH), .CH_W(CH_W)) u_commit (
        .clk(clk), .rst(rst), .fire(fire), .dac_clr(cfg.dac_clr), .send(send),
        .stg_flat(stg_flat), .dac_word(dac_word), .dac_strobe(dac_strobe)
    );

    assign cfg_bits = cfg;

    AST_STROBE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> (dac_strobe == '0)); // R3
endmodule

// File: tb/test_dac_frame_stager.sv
`timescale 1ns/1ps
module test_dac_frame_stager;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [511:0] wr_data = '0;
    logic [4:0]   wr_nwords = '0;
    logic [2:0]   grp_log2 = '0;
    logic         frame_start;
    logic [511:0] dac_word;
    logic [31:0]  dac_strobe;
    logic [3:0]   cfg_bits;
    logic [7:0]   led_bits;
    logic         align_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dac_frame_stager i_dac_frame_stager (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_nwords(wr_nwords), .grp_log2(grp_log2), .frame_start(frame_start),
        .dac_word(dac_word), .dac_strobe(dac_strobe), .cfg_bits(cfg_bits),
        .led_bits(led_bits), .align_err(align_err)
    );

    // {channel, code}
    localparam logic [20:0] VEC [6] = '{
        {5'd0,  16'h1234}, {5'd1,  16'hFFFF}, {5'd3,  16'h0000},
        {5'd16, 16'hA5A5}, {5'd30, 16'h0001}, {5'd31, 16'h7FFF}
    };

    function automatic logic [15:0] ch(input int n);
        return dac_word[n*16 +: 16];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [511:0] d, input logic [4:0] nw);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_nwords = nw;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!frame_start);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk(dac_word == {32{16'h8000}}, "R1 words", dac_word[31:0], 32'h80008000);
        chk(dac_strobe == 0 && cfg_bits == 0 && led_bits == 0 && !align_err,
            "R1 flags", {dac_strobe[15:0], 3'b0, align_err, cfg_bits, led_bits}, 0);

        // R2 frame period
        wait_frame();
        per = 0;
        do begin @(negedge clk); per++; end while (!frame_start);
        chk(per == 98, "R2 period", per, 98);

        // R3 single-channel vectors
        foreach (VEC[i]) begin
            do_write({3'b0, VEC[i][20:16]}, {496'b0, VEC[i][15:0]}, 5'd1);
            wait_frame();
            chk(ch(int'(VEC[i][20:16])) == VEC[i][15:0], "R3 code",
                ch(int'(VEC[i][20:16])), VEC[i][15:0]);
            chk(dac_strobe == (32'h1 << VEC[i][20:16]), "R3 strobe",
                dac_strobe, 32'h1 << VEC[i][20:16]);
        end
        @(negedge clk);
        chk(dac_strobe == 0, "R3 strobe off-frame", dac_strobe, 0);

        // R4 hold, R5 release
        do_write(8'h21, 512'h20, 5'd0);
        do_write(8'd5, 512'h5555, 5'd1);
        wait_frame();
        chk(ch(5) == 16'h8000 && dac_strobe == 0, "R4 held", {ch(5), dac_strobe[15:0]}, 32'h80000000);
        do_write(8'h20, 512'h20, 5'd0);
        wait_frame();
        chk(ch(5) == 16'h5555 && dac_strobe == 32'h20, "R5 release", {ch(5), dac_strobe[15:0]}, 32'h55550020);
        wait_frame();
        chk(dac_strobe == 0, "R5 self-clear", dac_strobe, 0);
        do_write(8'h21, 512'h0, 5'd0);

        // R6 continuous
        do_write(8'h25, 512'h80, 5'd0);
        wait_frame();
        chk(dac_strobe == 32'h80, "R6 first", dac_strobe, 32'h80);
        wait_frame();
        chk(dac_strobe == 32'h80 && ch(7) == 16'h8000, "R6 repeat", dac_strobe, 32'h80);
        do_write(8'h25, 512'h0, 5'd0);

        // R7 R8 group writes
        grp_log2 = 3'd2;
        do_write(8'd8, {{480{1'b1}}, 32'hBBBBAAAA}, 5'd1);
        wait_frame();
        chk(ch(8) == 16'hAAAA && ch(9) == 16'hBBBB, "R7 packing", {ch(9), ch(8)}, 32'hBBBBAAAA);
        chk(ch(10) == 0 && ch(11) == 0, "R8 zero fill", {ch(11), ch(10)}, 0);
        chk(dac_strobe == 32'h0F00, "R7 group strobe", dac_strobe, 32'h0F00);
        grp_log2 = 3'd1;
        do_write(8'd30, 512'h2222_1111, 5'd1);
        wait_frame();
        chk(ch(30) == 16'h1111 && ch(31) == 16'h2222, "R7 pair", {ch(31), ch(30)}, 32'h22221111);

        // R9 misaligned write ignored
        grp_log2 = 3'd2;
        do_write(8'd9, 512'h1357_2468, 5'd1);
        wait_frame();
        chk(ch(9) == 16'hBBBB && dac_strobe == 0, "R9 ignored", {ch(9), dac_strobe[15:0]}, 32'hBBBB0000);
        chk(align_err == 1'b1, "R9 sticky", align_err, 1);
        grp_log2 = 3'd0;

        // R10 config and LEDs
        do_write(8'h22, 512'h8, 5'd0);
        @(negedge clk);
        chk(cfg_bits == 4'h8 && !align_err, "R10 err clear", {cfg_bits, 3'b0, align_err}, 32'h80);
        do_write(8'h22, 512'h3, 5'd0);
        do_write(8'h23, 512'hA5, 5'd0);
        chk(cfg_bits == 4'h3 && led_bits == 8'hA5, "R10 fields", {cfg_bits, led_bits}, 32'h3A5);
        do_write(8'h22, 512'h0, 5'd0);

        // R11 clear to mid-scale
        wait_frame();
        do_write(8'h22, 512'h4, 5'd0);
        wait_frame();
        chk(dac_word == {32{16'h8000}}, "R11 mid", dac_word[31:0], 32'h80008000);
        chk(dac_strobe == 32'hFFFFFFFF, "R11 strobe", dac_strobe, 32'hFFFFFFFF);
        do_write(8'h22, 512'h0, 5'd0);

        // R12 write during frame_start deferred
        wait_frame();
        do_write(8'd2, 512'h7777, 5'd1);
        chk(ch(2) == 16'h8000, "R12 not this frame", ch(2), 32'h8000);
        wait_frame();
        chk(ch(2) == 16'h7777 && dac_strobe == 32'h4, "R12 next frame", {ch(2), dac_strobe[15:0]}, 32'h77770004);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule